// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Half-Word Masked Writes

This block is a memory-mapped GPIO controller. It is organised as a set of banks, and each bank holds up to 32 pins. It sits behind a plain 32-bit register bus made of an address, a write strobe, write data and read data. Each bank keeps three registers: output data, direction and output enable. The pad-side enable for a pin is set only when that pin is both configured as an output and enabled.

Software can change selected output bits in one bus write, with no read-modify-write. Each bank has two write-only ports for this, one for the lower 16 pins and one for the upper 16 pins. In each port the upper half-word selects which bits are left alone, and the lower half-word carries the new values.

Input pins pass through two flops before they can be read through a read-only level register. Banks can be narrower than 32 pins. A parameter can force two pins of bank 0 to stay outputs permanently.

Top module: `mbank_gpio`

## Requirements
- R1: After reset, every output data, direction and output-enable register is 0, except the forced direction bits of R8, so `pin_o` and `pin_oe_o` are all zero.
- R2: A write to byte offset 8*n is a low masked write to bank n. For each k in 0..15, output bit k takes `wdata_i[k]` when `wdata_i[16+k]` is 0, and keeps its old value when `wdata_i[16+k]` is 1. The change appears on `pin_o` after the clock edge at which the write is presented.
- R3: A write to offset 8*n+4 is a high masked write to bank n. It follows the same rule as R2, except that the bits it updates are output bits 16+k.
- R4: Offset 0x40+4*n is the full output data register of bank n. It can be read and written, and a write to one bank leaves every other bank unchanged.
- R5: Offset 0x60+4*n returns the pin levels of bank n as seen after a two-flop synchronizer. A change on `pin_i` is not visible after one clock edge and is visible after two. Writes to this offset are ignored.
- R6: Offset 0x204+0x40*n is the direction register of bank n, where 1 means output. Offset 0x208+0x40*n is its output-enable register. Both can be read and written. `pin_oe_o` bit = direction bit AND output-enable bit.
- R7: In a bank narrower than 32 pins, the bits at and above the bank width read as 0, ignore writes, and drive 0 on `pin_o` and `pin_oe_o`.
- R8: When `LOCK_OUT` is 1, direction bits 7 and 8 of bank 0 reset to 1, stay at 1, and writes of 0 to them are ignored.
- R9: Reads of the masked-write offsets and of unmapped offsets return 0.
- R10: `rdata_o` is combinational from `addr_i`, so a read has no wait cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| pin_i | input | NUM_BANKS*32 | Pin input levels, 32 bits per bank |
| pin_o | output | NUM_BANKS*32 | Output data, 32 bits per bank |
| pin_oe_o | output | NUM_BANKS*32 | Pad drive enable, 32 bits per bank |

## Verification
Register writes show up on `pin_o`, on `pin_oe_o` and in readback after the single clock edge at which they are presented. Reads are due in the same cycle as the address. The bench therefore drives each write in a low phase and checks results one falling edge later, never at a rising edge. Pin levels are due exactly two rising edges after `pin_i` changes. The bench reads the level register once after one edge, expecting the old value, and once after two edges, expecting the new value.

// File: rtl/mbg_pkg.sv
`timescale 1ns/1ps
package mbg_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned HALF_W    = 16;
  localparam int unsigned DATA_OFS  = 'h040;
  localparam int unsigned LVL_OFS   = 'h060;
  localparam int unsigned DIR_OFS   = 'h204;
  localparam int unsigned OE_OFS    = 'h208;
  localparam int unsigned CFG_STEP  = 'h040;
  localparam logic [WORD_W-1:0] LOCK_BITS = 32'h0000_0180;

  function automatic logic [WORD_W-1:0] width_mask(int unsigned w);
    if (w >= WORD_W) return '1;
    return (32'd1 << w) - 32'd1;
  endfunction
endpackage

// File: rtl/mbg_sync.sv
`timescale 1ns/1ps
module mbg_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/mbg_bank.sv
`timescale 1ns/1ps
module mbg_bank
  import mbg_pkg::*;
#(
  parameter int unsigned       WIDTH = 32,
  parameter logic [WORD_W-1:0] FORCE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic              data_we_i,
  input  logic              dir_we_i,
  input  logic              oe_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] data_o,
  output logic [WORD_W-1:0] dir_o,
  output logic [WORD_W-1:0] oe_o
);
  localparam logic [WORD_W-1:0] VALID  = width_mask(WIDTH);
  localparam logic [WORD_W-1:0] FORCED = FORCE & VALID;

  logic [WORD_W-1:0] data_q, dir_q, oe_q;
  logic [WORD_W-1:0] data_d, sel, val;
  logic [HALF_W-1:0] upd;

  // mask bit 0 selects an update
  always_comb begin
    upd = ~wdata_i[WORD_W-1:HALF_W];
    sel = '0;
    val = '0;
    if (lo_we_i) begin
      sel[HALF_W-1:0] = upd;
      val[HALF_W-1:0] = wdata_i[HALF_W-1:0];
    end else if (hi_we_i) begin
      sel[WORD_W-1:HALF_W] = upd;
      val[WORD_W-1:HALF_W] = wdata_i[HALF_W-1:0];
    end
    if (data_we_i) data_d = wdata_i & VALID;
    else           data_d = ((data_q & ~sel) | (val & sel)) & VALID;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= FORCED;
      oe_q   <= '0;
    end else begin
      data_q <= data_d;
      if (dir_we_i) dir_q <= (wdata_i | FORCED) & VALID;
      if (oe_we_i)  oe_q  <= wdata_i & VALID;
    end
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;
  assign oe_o   = oe_q;
endmodule

// File: rtl/mbank_gpio.sv
`timescale 1ns/1ps
module mbank_gpio
  import mbg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BANK_W [NUM_BANKS] = '{32, 22, 32, 32},
  parameter bit          LOCK_OUT  = 1'b1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        we_i,
  input  logic [WORD_W-1:0]           wdata_i,
  output logic [WORD_W-1:0]           rdata_o,
  input  logic [NUM_BANKS*WORD_W-1:0] pin_i,
  output logic [NUM_BANKS*WORD_W-1:0] pin_o,
  output logic [NUM_BANKS*WORD_W-1:0] pin_oe_o
);
  localparam int unsigned TOT_W = NUM_BANKS * WORD_W;

  logic [WORD_W-1:0] data_w [NUM_BANKS];
  logic [WORD_W-1:0] dir_w  [NUM_BANKS];
  logic [WORD_W-1:0] oe_w   [NUM_BANKS];
  logic [WORD_W-1:0] lvl_w  [NUM_BANKS];
  logic [TOT_W-1:0]  pin_s;

  mbg_sync #(.W(TOT_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [WORD_W-1:0] FRC = (b == 0 && LOCK_OUT) ? LOCK_BITS : '0;
    logic lo_we, hi_we, data_we, dir_we, oe_we;
    assign lo_we   = we_i && (addr_i == ADDR_W'(8 * b));
    assign hi_we   = we_i && (addr_i == ADDR_W'(8 * b + 4));
    assign data_we = we_i && (addr_i == ADDR_W'(DATA_OFS + 4 * b));
    assign dir_we  = we_i && (addr_i == ADDR_W'(DIR_OFS + CFG_STEP * b));
    assign oe_we   = we_i && (addr_i == ADDR_W'(OE_OFS + CFG_STEP * b));

    mbg_bank #(.WIDTH(BANK_W[b]), .FORCE(FRC)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lo_we_i  (lo_we),
      .hi_we_i  (hi_we),
      .data_we_i(data_we),
      .dir_we_i (dir_we),
      .oe_we_i  (oe_we),
      .wdata_i  (wdata_i),
      .data_o   (data_w[b]),
      .dir_o    (dir_w[b]),
      .oe_o     (oe_w[b])
    );

    assign lvl_w[b]                 = pin_s[b*WORD_W +: WORD_W] & width_mask(BANK_W[b]);
    assign pin_o[b*WORD_W +: WORD_W]    = data_w[b];
    assign pin_oe_o[b*WORD_W +: WORD_W] = dir_w[b] & oe_w[b];
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_i == ADDR_W'(DATA_OFS + 4 * b))          rdata_o = data_w[b];
      if (addr_i == ADDR_W'(LVL_OFS + 4 * b))           rdata_o = lvl_w[b];
      if (addr_i == ADDR_W'(DIR_OFS + CFG_STEP * b))    rdata_o = dir_w[b];
      if (addr_i == ADDR_W'(OE_OFS + CFG_STEP * b))     rdata_o = oe_w[b];
    end
  end
endmodule

// File: rtl/mbg_checker.sv
`timescale 1ns/1ps
module mbg_checker
  import mbg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BANK_W [NUM_BANKS] = '{32, 22, 32, 32},
  parameter bit          LOCK_OUT  = 1'b1
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [ADDR_W-1:0]           addr_i,
  input logic                        we_i,
  input logic [WORD_W-1:0]           wdata_i,
  input logic [WORD_W-1:0]           rdata_o,
  input logic [NUM_BANKS*WORD_W-1:0] pin_o,
  input logic [NUM_BANKS*WORD_W-1:0] pin_oe_o
);
  localparam logic [WORD_W-1:0] V0 = width_mask(BANK_W[0]);
  logic [NUM_BANKS*WORD_W-1:0] valid_all;
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_v
    assign valid_all[b*WORD_W +: WORD_W] = width_mask(BANK_W[b]);
  end

  // R2: low masked write on bank 0
  a_r2_masked_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(0)) |=>
      pin_o[HALF_W-1:0] == ((($past(pin_o[HALF_W-1:0]) & $past(wdata_i[WORD_W-1:HALF_W]))
                          | ($past(wdata_i[HALF_W-1:0]) & ~$past(wdata_i[WORD_W-1:HALF_W])))
                          & V0[HALF_W-1:0]));

  // R4: full data write on bank 0
  a_r4_full_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(DATA_OFS)) |=> pin_o[WORD_W-1:0] == ($past(wdata_i) & V0));

  // R7: bits above bank width stay low
  a_r7_narrow_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_o & ~valid_all) == '0) && ((pin_oe_o & ~valid_all) == '0));

  // R9: write-only offsets read as zero
  a_r9_wo_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(0) || addr_i == ADDR_W'(4)) |-> rdata_o == '0);

  if (LOCK_OUT) begin : g_lock
    // R8: forced outputs read back as output
    a_r8_lock_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == ADDR_W'(DIR_OFS)) |-> rdata_o[8:7] == 2'b11);
  end
endmodule

bind mbank_gpio mbg_checker #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .LOCK_OUT(LOCK_OUT)
) u_mbg_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o)
);

// File: tb/mbank_gpio_bench.sv
`timescale 1ns/1ps
module mbank_gpio_bench;
  localparam int NB = 4;
  localparam int AW = 12;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [AW-1:0]   addr_i = '0;
  logic            we_i = 1'b0;
  logic [31:0]     wdata_i = '0;
  logic [31:0]     rdata_o;
  logic [NB*32-1:0] pin_i = '0;
  logic [NB*32-1:0] pin_o, pin_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  mbank_gpio u_mbank_gpio (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  // kind: 0 read data, 1 pin_o bank, 2 pin_oe_o bank
  typedef struct {
    int          kind;
    int          idx;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  event  push_ev;

  initial begin
    forever begin
      @(push_ev);
      while (q.size() != 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0:       act = rdata_o;
          1:       act = pin_o[it.idx*32 +: 32];
          default: act = pin_oe_o[it.idx*32 +: 32];
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                   it.tag, it.kind, it.idx, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic expect_item(input int k, input int i, input logic [31:0] e, input string t);
    item_t it;
    it.kind = k; it.idx = i; it.exp = e; it.tag = t;
    q.push_back(it);
    ->push_ev;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b0;
    #1 expect_item(0, 0, e, t);
  endtask

  task automatic chk_pin(input int b, input logic [31:0] e, input string t);
    @(negedge clk_i);
    #1 expect_item(1, b, e, t);
  endtask

  task automatic chk_oe(input int b, input logic [31:0] e, input string t);
    @(negedge clk_i);
    #1 expect_item(2, b, e, t);
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk_pin(0, 32'h0, "R1 pin_o bank0");
    chk_oe(0, 32'h0, "R1 pin_oe bank0");
    rd(12'h040, 32'h0, "R1 data0");
    rd(12'h208, 32'h0, "R1 oe0");
    rd(12'h204, 32'h0000_0180, "R8 reset dir0");
    // R4 full data
    wr(12'h040, 32'hA5A5_1234);
    rd(12'h040, 32'hA5A5_1234, "R4 data0 readback");
    chk_pin(0, 32'hA5A5_1234, "R4 pin_o bank0");
    wr(12'h04C, 32'h1111_2222);
    rd(12'h040, 32'hA5A5_1234, "R4 bank isolation");
    // R2 low masked write: keep pins 15:8, load 7:0
    wr(12'h000, 32'hFF00_00AB);
    chk_pin(0, 32'hA5A5_12AB, "R2 low masked");
    // R3 high masked write
    wr(12'h004, 32'h0F0F_F0F0);
    chk_pin(0, 32'hF5F5_12AB, "R3 high masked");
    rd(12'h040, 32'hF5F5_12AB, "R10 same-cycle read");
    // R9 write-only and unmapped
    rd(12'h000, 32'h0, "R9 low port read");
    rd(12'h004, 32'h0, "R9 high port read");
    rd(12'h100, 32'h0, "R9 unmapped");
    // R6 / R8 direction and enable
    wr(12'h204, 32'h0000_FFFF);
    rd(12'h204, 32'h0000_FFFF, "R6 dir0 write");
    wr(12'h204, 32'h0000_0000);
    rd(12'h204, 32'h0000_0180, "R8 forced dir bits");
    wr(12'h204, 32'hFFFF_0000);
    rd(12'h204, 32'hFFFF_0180, "R8 forced with upper");
    wr(12'h208, 32'h0F0F_0F0F);
    rd(12'h208, 32'h0F0F_0F0F, "R6 oe0 readback");
    chk_oe(0, 32'h0F0F_0100, "R6 pin_oe and");
    // R7 narrow bank 1 (22 pins)
    wr(12'h044, 32'hFFFF_FFFF);
    rd(12'h044, 32'h003F_FFFF, "R7 data1 width");
    chk_pin(1, 32'h003F_FFFF, "R7 pin_o bank1");
    wr(12'h044, 32'h0);
    wr(12'h00C, 32'h0000_FFFF);
    chk_pin(1, 32'h003F_0000, "R7 high masked narrow");
    wr(12'h244, 32'hFFFF_FFFF);
    rd(12'h244, 32'h003F_FFFF, "R7 dir1 width");
    wr(12'h244, 32'h0);
    rd(12'h244, 32'h0, "R8 no force on bank1");
    // R5 synchronizer latency
    @(negedge clk_i);
    pin_i[31:0]  = 32'hDEAD_BEEF;
    pin_i[63:32] = 32'hFFFF_FFFF;
    rd(12'h060, 32'h0, "R5 one edge old");
    rd(12'h060, 32'hDEAD_BEEF, "R5 two edges new");
    rd(12'h064, 32'h003F_FFFF, "R5 R7 level bank1");
    wr(12'h060, 32'h0);
    rd(12'h060, 32'hDEAD_BEEF, "R5 write ignored");
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule